// File: doc/BRIEF.md
# Indexed Control-Register Target on a Two-Wire Bus

This block is a two-wire (SMBus) target that holds a small bank of byte-wide configuration registers for downstream clock-control logic. It oversamples SCL and SDA with the system clock. It recognises START, repeated START and STOP, and matches its device address. Register contents are presented continuously as one flat parallel vector.

A host writes by sending the write address, a starting register index, a byte count and then the data bytes. The target stores the data at consecutive indexes. To read, the host sends the write address and an index, then issues a repeated START with the read address. The target first returns a byte count, equal to the number of implemented registers, and then streams register bytes from the index onward, wrapping to register 0 after the last one. An active-low restore input reloads every register's power-up value on its falling edge.

Top module: `smbt_ctrl_target`

## Requirements
- R1: Only the 8-bit address bytes 0xD2 (write) and 0xD3 (read), that is 7-bit address 0x69 with the direction in bit 0, are acknowledged. Any other address byte is not acknowledged. The target then leaves SDA released, and ignores all further bytes until the next START or STOP.
- R2: After 0xD2, the target acknowledges an index byte N, a count byte X and X data bytes. The data bytes are stored in registers N, N+1, ... in order.
- R3: A data byte arriving after X data bytes have been stored is not acknowledged and is not stored.
- R4: A data byte whose target index is at or beyond the number of registers is acknowledged and discarded; no register changes.
- R5: After a repeated START with 0xD3, the first byte sent is the register count (5). Each host ACK then yields the next register, starting at the index last written. Register 4 is followed by register 0.
- R6: A host NACK after a read byte ends transmission: SDA stays released, and STOP returns the target to idle, ready for a new transfer.
- R7: After reset the registers hold 0xFF, 0x0F, 0xFF, 0x00, 0x00 for indexes 0 to 4. Register i appears on regs_out bits [8i+7:8i].
- R8: A falling edge on restore_n reloads the reset values of R7. Keeping restore_n low afterwards does not block or undo later writes.
- R9: sda_oe changes only while the synchronised SCL is low.
- R10: rst_n is a synchronous active-low reset. It releases SDA and restores the register values of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain enable) |
| restore_n | input | 1 | Asynchronous active-low restore; falling edge reloads defaults |
| regs_out | output | NREG*8 | All register bytes, register i at bits [8i+7:8i] |

## Verification
The bench builds the block with its default five registers and device address 0x69. It drives the bus with 8 system clocks per SCL half period, which leaves room for the three-cycle synchroniser and edge-detect latency. With only five registers, a short read crosses the wrap from register 4 to register 0. A write that starts at index 4 with a count of 3 also reaches the unimplemented indexes 5 and 6, so the discard and wrap cases fit in a few bytes each.

// File: rtl/smbt_pkg.sv
// Shared types and reset values for the two-wire control-register target.
// Assumes registers are indexed from 0 and are 8 bits wide.
package smbt_pkg;

    // Bus-level phase of the target
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting in a byte from the host
        ST_RACK,   // holding ACK low for the host
        ST_TX,     // shifting out a byte to the host
        ST_TACK,   // sampling the host's ACK/NACK
        ST_SKIP    // released, waiting for START or STOP
    } bus_st_e;

    // Meaning of the next byte received
    typedef enum logic [1:0] {
        K_ADDR,
        K_INDEX,
        K_COUNT,
        K_DATA
    } rx_kind_e;

    // Power-up value of register idx
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'h0F;
            2:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbt_sync.sv
// Two-flop synchroniser for asynchronous line inputs.
// Assumes the lines idle high, so the flops reset to all ones.
module smbt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two register stages to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/smbt_line_events.sv
// Turns synchronised SCL/SDA levels into single-cycle bus events:
// SCL edges, START (SDA falls with SCL high) and STOP (SDA rises with SCL high).
// Assumes inputs are already synchronised to clk.
module smbt_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d;
    logic sda_d;

    // Previous-cycle line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Event decode from current and previous levels
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/smbt_regbank.sv
// Bank of NREG byte registers with one write port, one read port and a
// restore strobe that reloads the power-up values.
// Assumes indexes at or beyond NREG select nothing (writes dropped, reads 0).
module smbt_regbank
    import smbt_pkg::*;
#(
    parameter int NREG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic              wr_en,
    input  logic [7:0]        wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_flat
);
    localparam logic [7:0] NREG_B = 8'(NREG);

    logic [7:0]        bank [NREG];
    logic [NREG*8-1:0] dflt_flat;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One register: reset/restore value or indexed write
        always_ff @(posedge clk) begin
            if (!rst_n || restore) begin
                bank[g] <= reg_default(g);
            end else if (wr_en && wr_idx == 8'(g)) begin
                bank[g] <= wr_data;
            end
        end
        assign regs_flat[g*8 +: 8] = bank[g];
    end

    // Read multiplexer, zero for unimplemented indexes
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == 8'(i)) rd_data = bank[i];
        end
    end

    // Expected power-up image, used by the checks below
    always_comb begin
        for (int i = 0; i < NREG; i++) dflt_flat[i*8 +: 8] = reg_default(i);
    end

    // R8: a restore strobe leaves every register at its power-up value
    a_r8_restore_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (regs_flat == dflt_flat));

    // R4: a write aimed past the last register changes nothing
    a_r4_oob_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= NREG_B && !restore) |=> $stable(regs_flat));
endmodule

// File: rtl/smbt_ctrl_target.sv
// Two-wire target with indexed block write and counted block read access
// to a bank of control registers. The bus is oversampled by clk; SDA is
// driven only through an open-drain enable, updated after SCL falls.
// Assumes clk is at least several times faster than SCL and that the host
// does not stretch or glitch the lines.
module smbt_ctrl_target
    import smbt_pkg::*;
#(
    parameter int         NREG     = 5,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              restore_n,
    output logic [NREG*8-1:0] regs_out
);
    localparam logic [7:0] CNT_B = 8'(NREG);

    logic scl_s, sda_s, restore_s, restore_d, restore_pulse;
    logic scl_rise, scl_fall, start_det, stop_det;

    bus_st_e    state;
    rx_kind_e   kind;
    logic [3:0] bitcnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_byte;
    logic [7:0] ptr;
    logic [7:0] remain;
    logic       rd_mode;
    logic       host_ack;

    logic       byte_done;
    logic       accept;
    logic       wr_en;
    logic [7:0] rd_data;
    logic [7:0] nxt_ptr;

    smbt_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in, restore_n}),
        .q     ({scl_s, sda_s, restore_s})
    );

    smbt_line_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Falling-edge detector on the synchronised restore line
    always_ff @(posedge clk) begin
        if (!rst_n) restore_d <= 1'b1;
        else        restore_d <= restore_s;
    end
    assign restore_pulse = restore_d & ~restore_s;

    // Byte-complete decode and acceptance decision
    always_comb begin
        byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
        case (kind)
            K_ADDR:  accept = (rx_sh[7:1] == DEV_ADDR);
            K_DATA:  accept = (remain != 8'd0);
            default: accept = 1'b1;
        endcase
        wr_en   = byte_done && (kind == K_DATA) && (remain != 8'd0);
        nxt_ptr = (ptr >= CNT_B - 8'd1) ? 8'd0 : ptr + 8'd1;
    end

    smbt_regbank #(.NREG(NREG)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .restore   (restore_pulse),
        .wr_en     (wr_en),
        .wr_idx    (ptr),
        .wr_data   (rx_sh),
        .rd_idx    (ptr),
        .rd_data   (rd_data),
        .regs_flat (regs_out)
    );

    // Protocol sequencer: byte framing, ACK handling and pointer updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= K_ADDR;
            bitcnt   <= 4'd0;
            rx_sh    <= 8'd0;
            tx_byte  <= 8'd0;
            ptr      <= 8'd0;
            remain   <= 8'd0;
            rd_mode  <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state   <= ST_RX;
            kind    <= K_ADDR;
            bitcnt  <= 4'd0;
            rd_mode <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sh  <= {rx_sh[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        if (accept) begin
                            sda_oe <= 1'b1;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_SKIP;
                        end
                        case (kind)
                            K_ADDR: begin
                                rd_mode <= rx_sh[0];
                                kind    <= K_INDEX;
                            end
                            K_INDEX: begin
                                ptr  <= rx_sh;
                                kind <= K_COUNT;
                            end
                            K_COUNT: begin
                                remain <= rx_sh;
                                kind   <= K_DATA;
                            end
                            default: begin
                                if (accept) begin
                                    ptr    <= ptr + 8'd1;
                                    remain <= remain - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        bitcnt <= 4'd0;
                        if (rd_mode) begin
                            state   <= ST_TX;
                            tx_byte <= CNT_B;
                            sda_oe  <= ~CNT_B[7];
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TACK;
                        end else begin
                            sda_oe <= ~tx_byte[3'(4'd7 - bitcnt)];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            tx_byte <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            ptr     <= nxt_ptr;
                            bitcnt  <= 4'd0;
                            state   <= ST_TX;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: the driven data line only moves while SCL is low
    a_r9_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R1/R6: nothing is driven while idle or after a NACK / foreign address
    a_r6_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe);

    // R5: the read pointer always lands inside the bank after a byte is loaded
    a_r5_read_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TACK && scl_fall && host_ack) |=> (ptr < CNT_B));

    // R2: a byte never carries more than eight data bits
    a_r2_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);
endmodule

// File: tb/smbt_ctrl_target_tb.sv
// Scoreboard bench: bus driver tasks push expected ACKs and bytes into a
// queue, the bus tasks push what they observe, and a monitor compares them.
module smbt_ctrl_target_tb;
    localparam int NREG = 5;
    localparam int Q    = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n     = 1'b0;
    logic scl       = 1'b1;
    logic host_low  = 1'b0;
    logic restore_n = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] regs;

    assign sda_line = ~(host_low | sda_oe);

    smbt_ctrl_target #(.NREG(NREG), .DEV_ADDR(7'h69)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .restore_n (restore_n),
        .regs_out  (regs)
    );

    int    n_chk   = 0;
    int    n_err   = 0;
    int    r9_viol = 0;
    bit    done    = 1'b0;
    int    exp_v[$];
    string exp_t[$];
    int    obs_v[$];
    logic [7:0] mdl  [NREG];
    logic [7:0] wbuf [8];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pair each observation with the oldest expectation
    always @(negedge clk) begin
        if (exp_v.size() > 0 && obs_v.size() > 0) begin
            chk(exp_t.pop_front(), obs_v.pop_front(), exp_v.pop_front());
        end
    end

    // R9 watcher: the target must not move SDA while SCL is high
    always @(sda_oe) begin
        if (scl && rst_n) r9_viol++;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_defaults();
        mdl[0] = 8'hFF; mdl[1] = 8'h0F; mdl[2] = 8'hFF; mdl[3] = 8'h00; mdl[4] = 8'h00;
    endtask

    task automatic chk_regs(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, int'(regs[i*8 +: 8]), int'(mdl[i]));
    endtask

    task automatic drain();
        while (exp_v.size() > 0 || obs_v.size() > 0) wt(1);
        wt(2);
    endtask

    task automatic bus_start();
        host_low = 1'b0; wt(Q);
        scl = 1'b1;      wt(Q);
        host_low = 1'b1; wt(Q);
        scl = 1'b0;      wt(1);
    endtask

    task automatic bus_stop();
        host_low = 1'b1; wt(Q);
        scl = 1'b1;      wt(Q);
        host_low = 1'b0; wt(Q);
    endtask

    // Host sends a byte, expects ack (1) or nack (0)
    task automatic send_byte(input logic [7:0] b, input int exp_ack, input string tag);
        exp_v.push_back(exp_ack);
        exp_t.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            host_low = ~b[i]; wt(Q);
            scl = 1'b1;       wt(Q);
            scl = 1'b0;       wt(1);
        end
        host_low = 1'b0; wt(Q);
        scl = 1'b1;      wt(Q / 2);
        obs_v.push_back(sda_line ? 0 : 1);
        wt(Q / 2);
        scl = 1'b0;      wt(1);
    endtask

    // Host reads a byte, then acks (1) or nacks (0)
    task automatic recv_byte(input logic [7:0] exp_b, input string tag, input logic give_ack);
        logic [7:0] b;
        b = 8'h00;
        exp_v.push_back(int'(exp_b));
        exp_t.push_back(tag);
        for (int i = 0; i < 8; i++) begin
            wt(Q);
            scl = 1'b1; wt(Q / 2);
            b = {b[6:0], sda_line};
            wt(Q / 2);
            scl = 1'b0; wt(1);
        end
        obs_v.push_back(int'(b));
        host_low = give_ack; wt(Q);
        scl = 1'b1;          wt(Q);
        scl = 1'b0;          wt(1);
        host_low = 1'b0;
    endtask

    task automatic wr_txn(input logic [7:0] idx, input int cnt, input int n, input string tag);
        bus_start();
        send_byte(8'hD2, 1, "R1 write address ack");
        send_byte(idx, 1, {tag, " index ack"});
        send_byte(8'(cnt), 1, {tag, " count ack"});
        for (int i = 0; i < n; i++) begin
            if (i < cnt) begin
                send_byte(wbuf[i], 1, {tag, " data ack"});
                if (int'(idx) + i < NREG) mdl[int'(idx) + i] = wbuf[i];
            end else begin
                send_byte(wbuf[i], 0, "R3 byte past count nack");
                break;
            end
        end
        bus_stop();
        drain();
    endtask

    task automatic rd_txn(input logic [7:0] idx, input int n);
        int p;
        bus_start();
        send_byte(8'hD2, 1, "R1 write address ack");
        send_byte(idx, 1, "R5 read index ack");
        bus_start();
        send_byte(8'hD3, 1, "R1 read address ack");
        recv_byte(8'(NREG), "R5 count byte", 1'b1);
        p = int'(idx);
        for (int k = 0; k < n; k++) begin
            recv_byte(mdl[p], "R5 read data", (k < n - 1) ? 1'b1 : 1'b0);
            p = (p + 1) % NREG;
        end
        wt(Q);
        chk("R6 released after host nack", int'(sda_oe), 0);
        bus_stop();
        drain();
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        load_defaults();
        wt(5);
        rst_n = 1'b1;
        wt(5);
        chk_regs("R7 reset value");
        chk("R10 sda released after reset", int'(sda_oe), 0);

        // R2: plain block write from index 0
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
        wr_txn(8'd0, 3, 3, "R2");
        chk_regs("R2 stored bytes");

        // R5: read from 0, then a read that wraps past register 4
        rd_txn(8'd0, 3);
        rd_txn(8'd3, 4);

        // R1: foreign and near-miss addresses are ignored
        bus_start();
        send_byte(8'hA0, 0, "R1 foreign address nack");
        send_byte(8'h00, 0, "R1 ignored after foreign address");
        bus_stop();
        bus_start();
        send_byte(8'hD0, 0, "R1 near-miss address nack");
        send_byte(8'h02, 0, "R1 ignored after near-miss");
        bus_stop();
        drain();
        chk_regs("R1 foreign write dropped");
        chk("R1 released after foreign address", int'(sda_oe), 0);

        // R3: one byte more than the count
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr_txn(8'd1, 2, 3, "R3");
        chk_regs("R3 extra byte not stored");

        // R4: write runs past the last register
        wbuf[0] = 8'h4D; wbuf[1] = 8'hEE; wbuf[2] = 8'h99;
        wr_txn(8'd4, 3, 3, "R4");
        chk_regs("R4 out-of-range bytes discarded");
        rd_txn(8'd4, 2);

        // R8: restore edge, then writes while restore is still low
        restore_n = 1'b0;
        wt(6);
        load_defaults();
        chk_regs("R8 restore reloads defaults");
        wbuf[0] = 8'h55;
        wr_txn(8'd2, 1, 1, "R8");
        chk_regs("R8 write accepted while restore held low");
        restore_n = 1'b1;
        wt(6);
        chk_regs("R8 release edge changes nothing");

        // R10: synchronous reset mid-run
        wbuf[0] = 8'h77;
        wr_txn(8'd1, 1, 1, "R10");
        chk_regs("R10 write before reset");
        @(negedge clk) rst_n = 1'b0;
        wt(3);
        rst_n = 1'b1;
        wt(3);
        load_defaults();
        chk_regs("R10 reset restores defaults");
        rd_txn(8'd0, 2);

        chk("R9 sda moved while scl high", r9_viol, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule